// File: doc/BRIEF.md
# Threshold Motion Interrupt Generator

The block watches three signed acceleration samples (X, Y, Z) and turns them into a qualified motion interrupt. Each time the sample strobe pulses, it takes the magnitude of every axis and compares it with a programmable threshold. Each axis can flag two events: a high event when the magnitude is above the threshold, and a low event when it is below. Six arm bits choose which of these events take part. The armed events are joined by either an OR or an AND to form the motion condition.

A duration counter qualifies the motion condition. The interrupt-active flag (IA) sets only after the condition has been seen on enough consecutive samples. When the condition drops, the counter either clears or steps down by one, as configured. A source register reports IA and the armed event flags. It can be latched: when latched, it holds its value and freezes the counter until it is read. A read strobe clears it.

An output multiplexer drives the interrupt pin. It can select this generator, a peer generator, the OR of the two, a data-ready signal, a click signal, or nothing. A polarity bit sets the active level of the pin.

The qualifier is a four-state machine:
- **QUIET**: the counter is zero and IA is clear.
- **QUALIFY**: the counter is non-zero but IA has not fired.
- **ACTIVE**: IA has fired and latching is off.
- **HELD**: IA has fired with latching on.

The transitions are:
- A sample that fires IA moves the machine to ACTIVE, or to HELD when latching is on.
- A sample that does not fire moves it to QUIET if the new count is zero, and to QUALIFY otherwise.
- In HELD, samples are ignored unless a read arrives in the same cycle.
- A read clears the source register. A read alone moves the machine to QUIET or QUALIFY, based on the count.

Top module: `motion_irq_gen`

## Requirements
- R1: After reset the source register reads 0, and with pin select 001 and polarity 0 the interrupt pin is 0.
- R2: On each strobe, per axis, the magnitude of the two's-complement sample is compared with thr_cfg[6:0]. The high event is set when the magnitude is greater than the threshold, and the low event when it is less. Equality sets neither. A sample of -128 has magnitude 128. Event bit order is bit0 X low, bit1 X high, bit2 Y low, bit3 Y high, bit4 Z low, bit5 Z high.
- R3: With and_mode = 0, the condition is true when at least one armed event is set.
- R4: With and_mode = 1, the condition is true only when every armed event is set. With no event armed, it is never true.
- R5: A true condition with count c fires IA when c >= dur_cfg; otherwise it increments the count. So IA first sets on qualifying sample dur_cfg+1, and a duration of 0 fires on the first sample.
- R6: With thr_cfg[7] = 0, a strobe with a false condition clears the count.
- R7: With thr_cfg[7] = 1, a strobe with a false condition decrements the count, stopping at zero.
- R8: Outside HELD, each strobe loads src_val = {0, IA, armed events & event flags}. Without a strobe or read, src_val does not change.
- R9: With latch_en = 1, a firing sample enters HELD. Later strobes change neither src_val nor the count until a read arrives.
- R10: A read strobe clears src_val. If a sample strobe arrives in the same cycle, the sample result is stored instead.
- R11: The pin source is chosen by pin_sel: 000 none, 001 this IA, 010 peer_irq, 011 IA or peer_irq, 100 data_rdy, 111 click_irq, and 101/110 none. The pin equals the selected value XOR pin_pol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per output sample |
| smp_x | input | 8 | X sample, two's complement |
| smp_y | input | 8 | Y sample, two's complement |
| smp_z | input | 8 | Z sample, two's complement |
| and_mode | input | 1 | 0: OR of armed events, 1: AND |
| latch_en | input | 1 | Latch source register until read |
| arm | input | 6 | Event arm bits, order as in R2 |
| thr_cfg | input | 8 | [7] decrement mode, [6:0] threshold |
| dur_cfg | input | 8 | Required duration in samples |
| src_rd | input | 1 | Source register read strobe (clears) |
| pin_sel | input | 3 | Interrupt pin source select |
| pin_pol | input | 1 | 0: active high, 1: active low |
| peer_irq | input | 1 | Interrupt of a second generator |
| data_rdy | input | 1 | Data-ready indication |
| click_irq | input | 1 | Click detector interrupt |
| src_val | output | 8 | Source register: [6] IA, [5:0] events |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The hardest case to reach is a frozen counter. The block must be in HELD with a non-zero count, receive non-qualifying samples that would otherwise clear the count, and then be read. The stimulus fires a latched interrupt at duration 2 and feeds quiet samples while held. After the read, a single qualifying sample must re-fire at once, which proves the count survived. The read-with-sample collision and the decrement floor at zero are also driven directly. Random configuration blocks revisit all of these in mixed orders.

// File: rtl/mig_pkg.sv
package mig_pkg;
    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_HELD    = 2'd3
    } mig_state_e;

    localparam int AXES       = 3;
    localparam int EV_PER_AX  = 2;
    localparam int NEV        = AXES * EV_PER_AX;

    localparam logic [2:0] SEL_NONE  = 3'b000;
    localparam logic [2:0] SEL_OWN   = 3'b001;
    localparam logic [2:0] SEL_PEER  = 3'b010;
    localparam logic [2:0] SEL_BOTH  = 3'b011;
    localparam logic [2:0] SEL_DRDY  = 3'b100;
    localparam logic [2:0] SEL_CLICK = 3'b111;
endpackage

// File: rtl/mig_axis_cmp.sv
module mig_axis_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] smp,
    input  logic [DW-2:0] thr,
    output logic          ev_hi,
    output logic          ev_lo
);
    localparam int TW = DW - 1;

    logic [DW-1:0] mag;
    logic [DW-1:0] thr_ext;

    assign mag     = smp[DW-1] ? (~smp + DW'(1)) : smp;
    assign thr_ext = {1'b0, thr[TW-1:0]};
    assign ev_hi   = (mag > thr_ext);
    assign ev_lo   = (mag < thr_ext);
endmodule

// File: rtl/mig_combine.sv
module mig_combine #(
    parameter int NEV = 6
) (
    input  logic [NEV-1:0] ev,
    input  logic [NEV-1:0] arm,
    input  logic           and_mode,
    output logic [NEV-1:0] ev_armed,
    output logic           cond
);
    always_comb begin
        ev_armed = ev & arm;
        if (and_mode) begin
            cond = (arm != '0) && (ev_armed == arm);
        end else begin
            cond = (ev_armed != '0);
        end
    end
endmodule

// File: rtl/mig_dur_fsm.sv
module mig_dur_fsm
    import mig_pkg::*;
#(
    parameter int NEV = 6,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic           src_rd,
    input  logic           latch_en,
    input  logic           dec_mode,
    input  logic [CW-1:0]  dur,
    input  logic           cond,
    input  logic [NEV-1:0] ev_armed,
    output logic [NEV:0]   src_q
);
    mig_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [NEV:0]  src_d;
    logic          take;
    logic          fire;
    logic [CW-1:0] cnt_eval;

    // Count step and firing decision for one evaluated sample
    always_comb begin
        fire     = 1'b0;
        cnt_eval = cnt_q;
        if (cond) begin
            if (cnt_q >= dur) begin
                fire = 1'b1;
            end else begin
                cnt_eval = cnt_q + CW'(1);
            end
        end else if (dec_mode) begin
            cnt_eval = (cnt_q == '0) ? '0 : (cnt_q - CW'(1));
        end else begin
            cnt_eval = '0;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        take  = 1'b0;
        unique case (st_q)
            ST_QUIET, ST_QUALIFY, ST_ACTIVE: begin
                take = smp_vld;
                if (!smp_vld && src_rd) begin
                    st_d = (cnt_q == '0) ? ST_QUIET : ST_QUALIFY;
                end
            end
            ST_HELD: begin
                if (src_rd) begin
                    take = smp_vld;
                    st_d = (cnt_q == '0) ? ST_QUIET : ST_QUALIFY;
                end
            end
            default: st_d = ST_QUIET;
        endcase
        if (take) begin
            cnt_d = cnt_eval;
            if (fire) begin
                st_d = latch_en ? ST_HELD : ST_ACTIVE;
            end else begin
                st_d = (cnt_eval == '0) ? ST_QUIET : ST_QUALIFY;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_QUIET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output (source register)
    always_comb begin
        src_d = src_q;
        if (src_rd) begin
            src_d = '0;
        end
        if (take) begin
            src_d = {fire, ev_armed};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_d;
        end
    end

    AST_SRC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !src_rd) |=> $stable(src_q)); // R8
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd && !smp_vld) |=> (src_q == '0)); // R10
    AST_HELD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD && !src_rd) |=> ($stable(cnt_q) && $stable(src_q))); // R9
    AST_RST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !cond && !dec_mode && st_q != ST_HELD) |=> (cnt_q == '0)); // R6
    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !cond && dec_mode && st_q != ST_HELD && cnt_q == '0) |=> (cnt_q == '0)); // R7
    AST_QUIET_NO_IA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_QUIET || st_q == ST_QUALIFY) |-> !src_q[NEV]); // R5
endmodule

// File: rtl/mig_pin_mux.sv
module mig_pin_mux
    import mig_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       pol,
    input  logic       own_ia,
    input  logic       peer_irq,
    input  logic       data_rdy,
    input  logic       click_irq,
    output logic       pin
);
    logic picked;

    always_comb begin
        unique case (sel)
            SEL_OWN:   picked = own_ia;
            SEL_PEER:  picked = peer_irq;
            SEL_BOTH:  picked = own_ia | peer_irq;
            SEL_DRDY:  picked = data_rdy;
            SEL_CLICK: picked = click_irq;
            default:   picked = 1'b0;
        endcase
        pin = picked ^ pol;
    end
endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
    import mig_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_x,
    input  logic [DW-1:0] smp_y,
    input  logic [DW-1:0] smp_z,
    input  logic          and_mode,
    input  logic          latch_en,
    input  logic [NEV-1:0] arm,
    input  logic [DW-1:0] thr_cfg,
    input  logic [CW-1:0] dur_cfg,
    input  logic          src_rd,
    input  logic [2:0]    pin_sel,
    input  logic          pin_pol,
    input  logic          peer_irq,
    input  logic          data_rdy,
    input  logic          click_irq,
    output logic [7:0]    src_val,
    output logic          irq_pin
);
    localparam int TW = DW - 1;

    logic [AXES-1:0][DW-1:0] axis_bus;
    logic [NEV-1:0]          ev;
    logic [NEV-1:0]          ev_armed;
    logic                    cond;
    logic [NEV:0]            src_q;

    assign axis_bus = {smp_z, smp_y, smp_x};

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        mig_axis_cmp #(.DW(DW)) u_cmp (
            .smp   (axis_bus[a]),
            .thr   (thr_cfg[TW-1:0]),
            .ev_hi (ev[EV_PER_AX*a + 1]),
            .ev_lo (ev[EV_PER_AX*a])
        );
    end

    mig_combine #(.NEV(NEV)) u_comb (
        .ev       (ev),
        .arm      (arm),
        .and_mode (and_mode),
        .ev_armed (ev_armed),
        .cond     (cond)
    );

    mig_dur_fsm #(.NEV(NEV), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .src_rd   (src_rd),
        .latch_en (latch_en),
        .dec_mode (thr_cfg[DW-1]),
        .dur      (dur_cfg),
        .cond     (cond),
        .ev_armed (ev_armed),
        .src_q    (src_q)
    );

    mig_pin_mux u_mux (
        .sel       (pin_sel),
        .pol       (pin_pol),
        .own_ia    (src_q[NEV]),
        .peer_irq  (peer_irq),
        .data_rdy  (data_rdy),
        .click_irq (click_irq),
        .pin       (irq_pin)
    );

    assign src_val = {{(7 - NEV){1'b0}}, src_q};

    AST_IA_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_val[6]) |-> (src_val[5:0] != 6'd0)); // R5
    AST_PIN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == SEL_NONE) |-> (irq_pin == pin_pol)); // R11
    AST_PIN_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == SEL_OWN) |-> (irq_pin == (src_val[6] ^ pin_pol))); // R11
endmodule

// File: tb/tb_motion_irq_gen.sv
module tb_motion_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic       and_mode = 1'b0, latch_en = 1'b0;
    logic [5:0] arm = '0;
    logic [7:0] thr_cfg = '0, dur_cfg = '0;
    logic       src_rd = 1'b0;
    logic [2:0] pin_sel = 3'b001;
    logic       pin_pol = 1'b0;
    logic       peer_irq = 1'b0, data_rdy = 1'b0, click_irq = 1'b0;
    logic [7:0] src_val;
    logic       irq_pin;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    int         m_cnt = 0;
    logic [7:0] m_src = '0;
    bit         m_held = 0;

    always #5 clk = ~clk;

    motion_irq_gen dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .and_mode(and_mode), .latch_en(latch_en), .arm(arm),
        .thr_cfg(thr_cfg), .dur_cfg(dur_cfg), .src_rd(src_rd),
        .pin_sel(pin_sel), .pin_pol(pin_pol), .peer_irq(peer_irq),
        .data_rdy(data_rdy), .click_irq(click_irq),
        .src_val(src_val), .irq_pin(irq_pin)
    );

    function automatic int mag_of(input logic [7:0] v);
        int s;
        s = int'($signed(v));
        return (s < 0) ? -s : s;
    endfunction

    // R2 event order: XL, XH, YL, YH, ZL, ZH at bits 0..5
    function automatic logic [5:0] events_of(input logic [7:0] x, y, z, input int thr);
        logic [5:0] e;
        e[0] = mag_of(x) < thr;  e[1] = mag_of(x) > thr;
        e[2] = mag_of(y) < thr;  e[3] = mag_of(y) > thr;
        e[4] = mag_of(z) < thr;  e[5] = mag_of(z) > thr;
        return e;
    endfunction

    function automatic bit pin_ref(input logic [2:0] sel, input bit pol, ia, peer, drdy, clk_i);
        bit p;
        case (sel)
            3'b001: p = ia;
            3'b010: p = peer;
            3'b011: p = ia | peer;
            3'b100: p = drdy;
            3'b111: p = clk_i;
            default: p = 1'b0;
        endcase
        return p ^ pol;
    endfunction

    task automatic model_step(input logic [7:0] x, y, z, input bit rd, input bit s);
        logic [5:0] ea;
        bit cnd, fire;
        if (s && !(m_held && !rd)) begin
            ea = events_of(x, y, z, int'(thr_cfg[6:0])) & arm;
            cnd = and_mode ? ((arm != 0) && (ea == arm)) : (ea != 0);
            fire = 0;
            m_held = 0;
            if (cnd) begin
                if (m_cnt >= int'(dur_cfg)) fire = 1; else m_cnt++;
            end else if (thr_cfg[7]) begin
                if (m_cnt > 0) m_cnt--;
            end else begin
                m_cnt = 0;
            end
            m_src = {1'b0, fire, ea};
            if (fire && latch_en) m_held = 1;
        end else if (rd) begin
            m_src = '0;
            m_held = 0;
        end
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [7:0] x, y, z, input bit rd, input bit s);
        @(negedge clk);
        smp_x = x; smp_y = y; smp_z = z;
        smp_vld = s; src_rd = rd;
        @(negedge clk);
        smp_vld = 1'b0; src_rd = 1'b0;
        model_step(x, y, z, rd, s);
        check(tag, src_val, m_src);
        check({tag, " R11 pin"}, {7'd0, irq_pin},
              {7'd0, pin_ref(pin_sel, pin_pol, m_src[6], peer_irq, data_rdy, click_irq)});
    endtask

    task automatic smp(input string tag, input logic [7:0] x, y, z);
        apply(tag, x, y, z, 1'b0, 1'b1);
    endtask

    task automatic rd(input string tag);
        apply(tag, 8'd0, 8'd0, 8'd0, 1'b1, 1'b0);
    endtask

    task automatic cfg(input bit am, input bit le, input logic [5:0] a,
                       input bit dec, input logic [6:0] th, input logic [7:0] du);
        and_mode = am; latch_en = le; arm = a;
        thr_cfg = {dec, th}; dur_cfg = du;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d5a7);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 src after reset", src_val, 8'h00);
        check("R1 pin after reset", {7'd0, irq_pin}, 8'h00);
        rst_n = 1'b1;

        // R2 magnitude compare and -128
        cfg(0, 0, 6'b000010, 0, 7'd127, 8'd0);
        smp("R2 -128 above 127", 8'h80, 8'd0, 8'd0);
        check("R2 -128 gives 42h", src_val, 8'h42);
        smp("R2 equal 127 neither", 8'd127, 8'd0, 8'd0);
        check("R2 equality gives 0", src_val, 8'h00);
        cfg(0, 0, 6'b000001, 0, 7'd5, 8'd0);
        smp("R2 low -4", 8'hFC, 8'd0, 8'd0);
        check("R2 low fires", src_val, 8'h41);
        smp("R2 low -5 equal", 8'hFB, 8'd0, 8'd0);

        // R3 OR
        cfg(0, 0, 6'b001010, 0, 7'd10, 8'd0);
        smp("R3 or x only", 8'd50, 8'd0, 8'd0);
        check("R3 or fires", src_val, 8'h42);
        smp("R3 or none", 8'd3, 8'd3, 8'd3);

        // R4 AND
        cfg(1, 0, 6'b010101, 0, 7'd20, 8'd0);
        smp("R4 and all low", 8'd5, 8'hFD, 8'd19);
        check("R4 and fires", src_val, 8'h55);
        smp("R4 and partial", 8'd5, 8'hFD, 8'd30);
        check("R4 and partial no IA", src_val, 8'h05);
        cfg(1, 0, 6'b000000, 0, 7'd20, 8'd0);
        smp("R4 and nothing armed", 8'd5, 8'd5, 8'd5);
        check("R4 empty arm no IA", src_val, 8'h00);

        // R5 duration 3, R6 reset mode
        cfg(0, 0, 6'b000010, 0, 7'd10, 8'd3);
        smp("R6 clear count", 8'd0, 8'd0, 8'd0);
        for (int i = 0; i < 3; i++) smp("R5 qualifying no IA", 8'd40, 8'd0, 8'd0);
        smp("R5 fourth fires", 8'd40, 8'd0, 8'd0);
        check("R5 IA on sample dur+1", src_val, 8'h42);
        smp("R6 drop", 8'd0, 8'd0, 8'd0);
        for (int i = 0; i < 3; i++) smp("R6 recount", 8'd40, 8'd0, 8'd0);
        check("R6 no IA after clear", src_val, 8'h02);

        // R7 decrement mode and floor
        cfg(0, 0, 6'b000010, 1, 7'd10, 8'd2);
        smp("R7 prep", 8'd0, 8'd0, 8'd0);
        smp("R7 q1", 8'd40, 8'd0, 8'd0);
        smp("R7 q2", 8'd40, 8'd0, 8'd0);
        smp("R7 n", 8'd0, 8'd0, 8'd0);
        smp("R7 q3 no fire", 8'd40, 8'd0, 8'd0);
        check("R7 partial count", src_val, 8'h02);
        smp("R7 q4 fires", 8'd40, 8'd0, 8'd0);
        check("R7 fire after dec", src_val, 8'h42);
        for (int i = 0; i < 5; i++) smp("R7 floor", 8'd0, 8'd0, 8'd0);
        cfg(0, 0, 6'b000010, 1, 7'd10, 8'd1);
        smp("R7 no wrap", 8'd40, 8'd0, 8'd0);
        check("R7 saturates at zero", src_val, 8'h02);

        // R9 latch and freeze
        cfg(0, 1, 6'b000010, 0, 7'd10, 8'd2);
        smp("R9 prep", 8'd0, 8'd0, 8'd0);
        rd("R9 prep rd");
        for (int i = 0; i < 3; i++) smp("R9 qualify", 8'd40, 8'd0, 8'd0);
        check("R9 latched IA", src_val, 8'h42);
        for (int i = 0; i < 3; i++) smp("R9 held quiet", 8'd0, 8'd0, 8'd0);
        check("R9 held value", src_val, 8'h42);
        rd("R10 read clears");
        check("R10 cleared", src_val, 8'h00);
        smp("R9 frozen count refires", 8'd40, 8'd0, 8'd0);
        check("R9 immediate refire", src_val, 8'h42);

        // R10 read with sample
        apply("R10 read+sample", 8'd0, 8'd0, 8'd0, 1'b1, 1'b1);
        check("R10 sample wins", src_val, 8'h00);
        cfg(0, 0, 6'b000010, 0, 7'd10, 8'd0);
        apply("R10 read+sample fire", 8'd40, 8'd0, 8'd0, 1'b1, 1'b1);
        check("R10 sample result kept", src_val, 8'h42);
        rd("R10 read non-latched");
        check("R10 read clear", src_val, 8'h00);

        // R11 pin mux codes and polarity
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 2; p++) begin
                pin_sel = 3'(s); pin_pol = p[0];
                peer_irq = s[0]; data_rdy = 1'b1; click_irq = 1'b1;
                smp("R11 mux", 8'd40, 8'd0, 8'd0);
            end
        end

        // Random phase
        for (int it = 0; it < 600; it++) begin
            logic [7:0] vx, vy, vz;
            if (it % 40 == 0) begin
                cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    6'($urandom), 1'($urandom_range(0, 1)),
                    7'($urandom_range(0, 127)), 8'($urandom_range(0, 3)));
            end
            pin_sel = 3'($urandom); pin_pol = 1'($urandom);
            peer_irq = 1'($urandom); data_rdy = 1'($urandom); click_irq = 1'($urandom);
            vx = ($urandom_range(0, 5) == 0) ? 8'h80 : 8'($urandom);
            vy = ($urandom_range(0, 3) == 0) ? {1'b0, thr_cfg[6:0]} : 8'($urandom);
            vz = 8'($urandom_range(0, 3) == 0 ? 0 : $urandom);
            apply("R8 random", vx, vy, vz, $urandom_range(0, 4) == 0, $urandom_range(0, 4) != 0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule